// File: doc/BRIEF.md
# Variable-Width SPI Master

A single-chip-select SPI master driven through a small register port. Software pushes transmit words into a 4-entry FIFO. Each word carries its own shift length in its top byte and up to 24 payload bits, left-aligned, below it. The shifter pops one word at a time and clocks that many bits out on MOSI, MSB first. It samples MISO on the same bit clock and pushes the assembled, right-aligned result into a 4-entry receive FIFO.

Two write addresses feed the same transmit FIFO. The choice of address decides what chip select does once that chunk is done: the hold-data address keeps it asserted so the next chunk continues the same frame, and the data address releases it. Two idle bit-clock periods separate any two chunks.

The bit clock runs at the core clock divided by 2×(SPEED+1). Polarity is selectable. A level interrupt can be raised on an empty transmit FIFO, on idle, or on both.

Top module: `spi_varlen_master`

## Requirements
- R1: After reset the status word reads 0x0000_0280 (TX empty and RX empty set, everything else clear), `cs_n` is high, `sclk` is low and `irq` is low.
- R2: With SPEED in control word 0 bits 31:20, one `sclk` period lasts 2×(SPEED+1) core clock cycles. SPEED=0 gives core/2.
- R3: A transmit word holds the bit count n (1 to 24) in bits 31:24 and its payload left-aligned in bits 23:0. Exactly n bits are shifted, and payload bit 23 goes out on MOSI first.
- R4: Each completed chunk pushes one RX entry holding the n sampled MISO bits. The first bit sampled is the most significant, and the last sampled bit lands in bit 0. A read of the data address (2'b11 offset 3) pops the entries in chunk order.
- R5: A word written at address 4 (hold) leaves `cs_n` low after its chunk. A word written at address 3 (data) returns `cs_n` high when its chunk completes.
- R6: Between the last bit-clock edge of one chunk and the first of the next, at least two full `sclk` periods pass with `sclk` at its idle level.
- R7: Control word 0 bit 7 (CPOL) is the idle level of `sclk`. MISO is sampled on the leading edge (rising when CPOL=0) and MOSI changes on the trailing edge (rising when CPOL=1).
- R8: Status (address 2) gives the TX level in bits 31:24 and the RX level in bits 23:16. Bit 10 is TX full, bit 9 TX empty, bit 8 RX full, bit 7 RX empty, bit 6 busy, and bits 5:0 hold the bits still left in the current chunk.
- R9: `irq` is high when control word 1 bit 7 is set and the TX FIFO is empty, or when bit 6 is set and the block is idle (TX FIFO empty and not busy). With both bits clear, `irq` stays low.
- R10: A write to control word 0 with bit 9 set empties both FIFOs. The bit does not stay set.
- R11: No chunk starts while control word 0 bit 11 (enable) is clear. Queued words wait and start once enable is set.
- R12: A write to the data or hold address while the TX FIFO holds 4 words is dropped. A data-address read with the RX FIFO empty returns zero and leaves the RX level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX on the data address) |
| reg_addr | input | 3 | 0 ctrl0, 1 ctrl1, 2 status, 3 data, 4 hold-data |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| sclk | output | 1 | SPI bit clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume three things about the inputs. `reg_wr` and `reg_rd` are never raised in the same cycle. `miso` changes only between sampling edges. The control words are not rewritten while a chunk is shifting. The bench keeps to these rules. It issues register accesses one at a time on the falling core-clock edge. It waits for status to report idle before changing speed or polarity. Its slave model advances `miso` only right after a leading `sclk` edge, so each bit stays stable through the sampling edge that follows.

// File: rtl/spi_varlen_master.sv
module spi_varlen_master #(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = 24;
  localparam logic [2:0] A_CTL0 = 3'd0, A_CTL1 = 3'd1, A_STAT = 3'd2, A_DATA = 3'd3, A_HOLD = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} st_t;

  logic [31:0] ctl0, ctl1;
  wire [11:0] speed = ctl0[31:20];
  wire        en    = ctl0[11];
  wire        cpol  = ctl0[7];

  st_t st;
  logic [11:0] div_cnt;
  logic        half, sclk_act, cs_r, hold_r;
  logic [5:0]  bits_left;
  logic [1:0]  gap_cnt;
  logic [PW-1:0] txsh, rxsh;

  logic [32:0]   tx_mem [DEPTH];
  logic [PW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  wire tx_full  = tx_cnt == CW'(DEPTH);
  wire tx_empty = tx_cnt == '0;
  wire rx_full  = rx_cnt == CW'(DEPTH);
  wire rx_empty = rx_cnt == '0;
  wire busy     = st != S_IDLE;
  wire tick     = div_cnt == speed;

  wire flush   = reg_wr && reg_addr == A_CTL0 && reg_wdata[9];
  wire tx_push = reg_wr && (reg_addr == A_DATA || reg_addr == A_HOLD) && !tx_full;
  wire tx_pop  = st == S_IDLE && en && !tx_empty;
  wire done    = st == S_SHIFT && tick && half && bits_left == 6'd1;
  wire rx_push = done && !rx_full;
  wire rx_pop  = reg_rd && reg_addr == A_DATA && !rx_empty;

  wire [32:0] tx_head = tx_mem[tx_rp];
  wire [7:0]  nreq    = tx_head[31:24];
  wire [5:0]  nld     = (nreq == 8'd0) ? 6'd1 : (nreq > 8'd24) ? 6'd24 : nreq[5:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl0 <= '0;
      ctl1 <= '0;
    end else if (reg_wr && reg_addr == A_CTL0) ctl0 <= reg_wdata & ~32'h200;
    else if (reg_wr && reg_addr == A_CTL1)    ctl1 <= reg_wdata;

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= {reg_addr == A_HOLD, reg_wdata};
    if (rx_push) rx_mem[rx_wp] <= rxsh;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (flush) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; div_cnt <= '0; half <= 1'b0; sclk_act <= 1'b0;
      cs_r <= 1'b0; hold_r <= 1'b0; bits_left <= '0; gap_cnt <= '0;
      txsh <= '0; rxsh <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          div_cnt <= '0;
          if (tx_pop) begin
            st <= S_SHIFT; txsh <= tx_head[PW-1:0]; bits_left <= nld;
            hold_r <= tx_head[32]; cs_r <= 1'b1; rxsh <= '0; half <= 1'b0;
          end
        end
        S_SHIFT: begin
          div_cnt <= tick ? '0 : div_cnt + 1'b1;
          if (tick) begin
            if (!half) begin
              sclk_act <= 1'b1;
              rxsh <= {rxsh[PW-2:0], miso};
              half <= 1'b1;
            end else begin
              sclk_act <= 1'b0;
              half <= 1'b0;
              txsh <= {txsh[PW-2:0], 1'b0};
              bits_left <= bits_left - 1'b1;
              if (bits_left == 6'd1) begin
                st <= S_GAP; gap_cnt <= '0;
                if (!hold_r) cs_r <= 1'b0;
              end
            end
          end
        end
        default: begin
          div_cnt <= tick ? '0 : div_cnt + 1'b1;
          if (tick) begin
            gap_cnt <= gap_cnt + 1'b1;
            if (gap_cnt == 2'd3) st <= S_IDLE;
          end
        end
      endcase
    end

  assign sclk = sclk_act ^ cpol;
  assign mosi = txsh[PW-1];
  assign cs_n = ~cs_r;
  assign irq  = (ctl1[7] & tx_empty) | (ctl1[6] & tx_empty & ~busy);

  wire [31:0] status = {8'(tx_cnt), 8'(rx_cnt), 5'b0, tx_full, tx_empty, rx_full, rx_empty, busy, bits_left};

  always_comb
    case (reg_addr)
      A_CTL0:  reg_rdata = ctl0;
      A_CTL1:  reg_rdata = ctl1;
      A_STAT:  reg_rdata = status;
      A_DATA:  reg_rdata = rx_empty ? 32'd0 : {8'd0, rx_mem[rx_rp]};
      default: reg_rdata = 32'd0;
    endcase

  // R12
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == A_DATA || reg_addr == A_HOLD) && tx_full && !tx_pop) |=> tx_cnt == $past(tx_cnt));
  // R12
  rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_DATA && rx_empty) |-> (reg_rdata == 32'd0));
  // R5
  cs_during_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT) |-> !cs_n);
  // R6
  gap_idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GAP) |-> (sclk == cpol));
  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl1[7:6] == 2'b00) |-> !irq);
  // R4
  rx_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && !rx_push && !flush) |=> rx_cnt == $past(rx_cnt) - 1'b1);
endmodule

// File: tb/spi_varlen_master_test.sv
module spi_varlen_master_test;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic sclk, mosi, miso, cs_n, irq;

  always #2 clk = ~clk;

  spi_varlen_master uut (.clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata,
    .reg_rdata, .sclk, .mosi, .miso, .cs_n, .irq);

  int checks = 0, fails = 0;
  bit finished = 0;

  localparam logic [63:0] PAT = 64'hA5C3_96E1_0F7B_3D28;
  int sidx = 0;
  logic cpol_b = 0;
  logic [31:0] sin = 0;
  int sin_n = 0;
  longint prev_lead, last_trail, min_per, max_gap;
  bit have_lead = 0, have_trail = 0;

  assign miso = PAT[63 - (sidx % 64)];

  always @(sclk) begin
    if (!cs_n) begin
      if (sclk != cpol_b) begin
        sin = {sin[30:0], mosi}; sin_n++; sidx++;
        if (have_lead && ($time - prev_lead) < min_per) min_per = $time - prev_lead;
        if (have_trail && ($time - last_trail) > max_gap) max_gap = $time - last_trail;
        prev_lead = $time; have_lead = 1;
      end else begin
        last_trail = $time; have_trail = 1;
      end
    end
  end

  task automatic reset_track();
    have_lead = 0; have_trail = 0; min_per = 1000000; max_gap = 0;
    sin = 0; sin_n = 0;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    do rd(3'd2, s); while (s[6] || !s[9]);
  endtask

  function automatic logic [31:0] ctl(int spd, bit en, bit cp);
    return (32'(spd) << 20) | (en ? 32'h800 : 0) | (cp ? 32'h80 : 0);
  endfunction

  function automatic logic [31:0] exp_rx(int s, int n);
    logic [31:0] r = 0;
    for (int i = 0; i < n; i++) r = {r[30:0], PAT[63 - ((s + i) % 64)]};
    return r;
  endfunction

  localparam int NV = 6;
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 32'h08A5_0000}, {1'b0, 32'h103C_C300}, {1'b0, 32'h1812_3456},
    {1'b1, 32'h05F8_0000}, {1'b0, 32'h0CAB_C000}, {1'b0, 32'h0180_0000}};

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int s0, n;
    #10 rst_n = 1;
    @(negedge clk);
    // R1 R8 reset state
    rd(3'd2, v); chk("R1 status", v, 32'h0000_0280);
    chk("R1 cs_n", cs_n, 1); chk("R1 sclk", sclk, 0); chk("R1 irq", irq, 0);

    // R11 enable gating
    wr(3'd0, ctl(1, 0, 0));
    wr(3'd3, 32'h0899_0000);
    repeat (40) @(negedge clk);
    rd(3'd2, v);
    chk("R11 busy while disabled", v[6], 0);
    chk("R11 tx level held", v[31:24], 1);
    chk("R11 cs_n idle", cs_n, 1);
    s0 = sidx; reset_track();
    wr(3'd0, ctl(1, 1, 0));
    wait_idle();
    chk("R11 mosi after enable", sin, 32'h99);
    rd(3'd3, v); chk("R11 rx after enable", v, exp_rx(s0, 8));

    // R3 R4 R5 table
    for (int i = 0; i < NV; i++) begin
      n = VEC[i][31:24]; s0 = sidx; reset_track();
      wr(VEC[i][32] ? 3'd4 : 3'd3, VEC[i][31:0]);
      wait_idle();
      chk("R3 bit count", sin_n, n);
      chk("R3 mosi bits", sin, 32'(VEC[i][23:0] >> (24 - n)));
      rd(3'd3, v); chk("R4 rx word", v, exp_rx(s0, n));
      chk("R5 cs after chunk", cs_n, !VEC[i][32]);
    end

    // R2 R6 period and gap at SPEED=2
    wr(3'd0, ctl(2, 1, 0));
    s0 = sidx; reset_track();
    wr(3'd4, 32'h08C3_0000); wr(3'd4, 32'h083C_0000);
    wait_idle();
    chk("R2 period speed2", 32'(min_per), 32'd24);
    chk("R6 gap lower", 32'(max_gap >= 48), 1);
    chk("R6 gap upper", 32'(max_gap <= 64), 1);
    chk("R5 held across chunks", cs_n, 0);
    rd(3'd3, v); chk("R4 order first", v, exp_rx(s0, 8));
    rd(3'd3, v); chk("R4 order second", v, exp_rx(s0 + 8, 8));
    wr(3'd3, 32'h0400_0000); wait_idle(); rd(3'd3, v);
    chk("R5 released", cs_n, 1);

    // R2 SPEED=0
    wr(3'd0, ctl(0, 1, 0)); reset_track();
    wr(3'd3, 32'h0855_0000); wait_idle();
    chk("R2 period speed0", 32'(min_per), 32'd8);
    rd(3'd3, v);

    // R8 R12 levels and empty read
    s0 = sidx;
    wr(3'd3, 32'h0811_0000); wr(3'd3, 32'h0822_0000); wr(3'd3, 32'h0833_0000);
    wait_idle();
    rd(3'd2, v);
    chk("R8 rx level", v[23:16], 3); chk("R8 rx empty flag", v[7], 0);
    for (int i = 0; i < 3; i++) begin
      rd(3'd3, v); chk("R4 queued rx", v, exp_rx(s0 + 8 * i, 8));
    end
    rd(3'd3, v); chk("R12 empty read zero", v, 0);
    rd(3'd2, v); chk("R12 rx level kept", v[23:16], 0);

    // R12 R10 full drop and flush
    wr(3'd3, 32'h0801_0000); wait_idle();
    wr(3'd0, ctl(0, 0, 0));
    for (int i = 0; i < 5; i++) wr(3'd3, 32'h0800_0000 | 32'(i));
    rd(3'd2, v);
    chk("R12 tx level at full", v[31:24], 4); chk("R8 tx full flag", v[10], 1);
    chk("R8 rx level one", v[23:16], 1);
    wr(3'd0, 32'h200);
    rd(3'd2, v); chk("R10 flushed", v, 32'h0000_0280);
    rd(3'd0, v); chk("R10 bit not kept", v[9], 0);

    // R9 interrupts
    wr(3'd1, 32'h80); #1 chk("R9 tx empty irq", irq, 1);
    wr(3'd3, 32'h0800_0000); #1 chk("R9 tx nonempty no irq", irq, 0);
    wr(3'd1, 32'h40); wr(3'd0, ctl(20, 1, 0));
    repeat (10) @(negedge clk);
    chk("R9 no idle irq while busy", irq, 0);
    wait_idle(); #1 chk("R9 idle irq", irq, 1);
    rd(3'd3, v);
    wr(3'd1, 0); #1 chk("R9 masked", irq, 0);

    // R7 CPOL=1
    cpol_b = 1;
    wr(3'd0, ctl(1, 1, 1));
    chk("R7 idle high", sclk, 1);
    s0 = sidx; reset_track();
    wr(3'd3, 32'h0A6D_4000); wait_idle();
    chk("R7 mosi cpol1", sin, 32'h1B5);
    rd(3'd3, v); chk("R7 rx cpol1", v, exp_rx(s0, 10));
    chk("R7 idle high after", sclk, 1);

    finish_run();
  end
endmodule